// File: doc/BRIEF.md
# CSR Access Permission Checker

This block judges one control-and-status-register access per request for a RISC-V style core and reports whether it may go ahead. When it may not, the block names the exception: illegal instruction or virtual instruction. The decision looks at several things:

- the 12-bit CSR address and whether the access intends to write;
- the current privilege mode and the virtualization bit;
- a CSR-instruction enable bit;
- the configured privileged-spec version;
- a small table of known CSRs, each with the minimum spec version it needs.

The checks run in a fixed order, and only the first one that fails sets the result. The enable check comes first. The existence check comes next, and a CSR whose version requirement exceeds the configured version counts as absent. Access control comes last.

The CSR table is a small associative store with a slot-indexed write port. The controlling logic fills it before requests are issued. Each slot holds a CSR address, an exists bit and a 2-bit minimum version. A request is a single-cycle pulse on `req_valid_i`. The verdict appears one clock later with a one-cycle `valid_o` pulse, and `result_o` holds that verdict until the next request.

Top module: `csr_access_checker`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `result_o` is 2'b00 (none).
- R2: `valid_o` is high in the cycle after `req_valid_i` was high and low otherwise. `result_o` changes only one cycle after a request and keeps its value across idle cycles.
- R3: With `csr_en_i` low, every request returns 2'b01 (illegal), whatever the address, mode or table contents.
- R4: An address that matches no table slot with its exists bit set returns 2'b01 (illegal), in every mode.
- R5: A table entry whose minimum version is greater than `cfg_ver_i` counts as absent and returns 2'b01 (illegal). This holds even where access control would otherwise give virtual instruction.
- R6: A CSR is read-only when address bits [11:10] equal 2'b11. A write-intent access to it returns 2'b01 (illegal), and this check comes before the privilege check. A read of the same CSR is judged on privilege alone.
- R7: The required level comes from address bits [9:8] (0 user, 1 supervisor, 2 hypervisor, 3 machine). The privilege encoding is 2'b00 user, 2'b01 supervisor and 2'b11 machine. Without virtualization:
  - machine mode reaches every level;
  - supervisor mode reaches levels 0 to 2;
  - user mode reaches only level 0;
  - any other access returns 2'b01 (illegal).
- R8: With `virt_i` high and privilege supervisor (virtual supervisor), a hypervisor-level CSR that exists returns 2'b10 (virtual), while supervisor- and user-level CSRs pass. With `virt_i` high and privilege user, supervisor- and hypervisor-level CSRs that exist return 2'b10 (virtual).
- R9: A machine-level CSR accessed in a virtualized mode returns 2'b01 (illegal), never virtual.
- R10: `result_o` never carries 2'b11. A passing access returns 2'b00.
- R11: A write on the table port replaces the whole slot before the next request is judged. Clearing a slot's exists bit makes its address absent, and a newly written address becomes present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table slot write enable |
| tbl_slot_i | input | 3 | Slot being written |
| tbl_csr_i | input | 12 | CSR address stored in the slot |
| tbl_exists_i | input | 1 | Slot holds an implemented CSR |
| tbl_minver_i | input | 2 | Minimum spec version for that CSR |
| req_valid_i | input | 1 | Request pulse |
| req_csr_i | input | 12 | CSR address of the access |
| req_wr_i | input | 1 | Access intends to write |
| priv_i | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| virt_i | input | 1 | Virtualization active |
| csr_en_i | input | 1 | CSR instructions enabled |
| cfg_ver_i | input | 2 | Configured privileged-spec version |
| valid_o | output | 1 | Verdict strobe, one cycle after request |
| result_o | output | 2 | 00 none, 01 illegal, 10 virtual |

## Verification
The assertions assume that every input is known at each rising edge, and that `priv_i` carries only the three defined encodings when `virt_i` is high. They also assume that no two slots hold the same address with the exists bit set. The stimulus keeps within these limits in three ways. It changes inputs only on falling edges and drives only user, supervisor and machine codes. It loads each slot with a distinct address while no request is outstanding.

// File: rtl/csr_chk_pkg.sv
package csr_chk_pkg;
  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_ILLEGAL = 2'b01,
    RES_VIRTUAL = 2'b10
  } csr_res_e;

  typedef enum logic [1:0] {
    PRV_U   = 2'b00,
    PRV_S   = 2'b01,
    PRV_RSV = 2'b10,
    PRV_M   = 2'b11
  } prv_e;

  typedef enum logic [1:0] {
    LVL_USER  = 2'b00,
    LVL_SUPV  = 2'b01,
    LVL_HYP   = 2'b10,
    LVL_MACH  = 2'b11
  } csr_lvl_e;
endpackage

// File: rtl/csr_attr_cam.sv
module csr_attr_cam #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VER_W   = 2,
  parameter int unsigned AW      = 12,
  localparam int unsigned SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic              wexists_i,
  input  logic [VER_W-1:0]  wver_i,
  input  logic [AW-1:0]     laddr_i,
  output logic              hit_o,
  output logic [VER_W-1:0]  ver_o
);
  logic [AW-1:0]    tag_q [ENTRIES];
  logic             ex_q  [ENTRIES];
  logic [VER_W-1:0] ver_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        ex_q[i]  <= 1'b0;
        ver_q[i] <= '0;
      end
    end else if (we_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (slot_i == SLOT_W'(i)) begin
          tag_q[i] <= waddr_i;
          ex_q[i]  <= wexists_i;
          ver_q[i] <= wver_i;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign match[g] = ex_q[g] && (tag_q[g] == laddr_i);
  end

  // Slots are expected to hold distinct addresses; OR-merge keeps the mux shallow.
  always_comb begin
    ver_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) ver_o = ver_o | ver_q[i];
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/csr_priv_gate.sv
module csr_priv_gate
  import csr_chk_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [1:0]    priv_i,
  input  logic          virt_i,
  output logic          ro_fault_o,
  output logic          deny_ill_o,
  output logic          deny_virt_o
);
  csr_lvl_e need;
  prv_e     mode;
  logic     guest;

  assign need       = csr_lvl_e'(addr_i[9:8]);
  assign mode       = prv_e'(priv_i);
  assign ro_fault_o = wr_i && (addr_i[11:10] == 2'b11);
  assign guest      = virt_i && (mode != PRV_M);

  always_comb begin
    deny_ill_o  = 1'b0;
    deny_virt_o = 1'b0;
    if (guest) begin
      if (need == LVL_MACH) deny_ill_o = 1'b1;
      else if (mode == PRV_S) deny_virt_o = (need == LVL_HYP);
      else deny_virt_o = (need != LVL_USER);
    end else begin
      unique case (mode)
        PRV_M:   deny_ill_o = 1'b0;
        PRV_S:   deny_ill_o = (need == LVL_MACH);
        default: deny_ill_o = (need != LVL_USER);
      endcase
    end
  end
endmodule

// File: rtl/csr_access_checker.sv
module csr_access_checker
  import csr_chk_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VER_W   = 2,
  parameter int unsigned CSR_AW  = 12,
  localparam int unsigned SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [SLOT_W-1:0] tbl_slot_i,
  input  logic [CSR_AW-1:0] tbl_csr_i,
  input  logic              tbl_exists_i,
  input  logic [VER_W-1:0]  tbl_minver_i,
  input  logic              req_valid_i,
  input  logic [CSR_AW-1:0] req_csr_i,
  input  logic              req_wr_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic              csr_en_i,
  input  logic [VER_W-1:0]  cfg_ver_i,
  output logic              valid_o,
  output logic [1:0]        result_o
);
  logic             hit;
  logic [VER_W-1:0] need_ver;
  logic             ro_fault, deny_ill, deny_virt;
  csr_res_e         res_d, res_q;
  logic             valid_q;

  csr_attr_cam #(.ENTRIES(ENTRIES), .VER_W(VER_W), .AW(CSR_AW)) u_cam (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we_i),
    .slot_i    (tbl_slot_i),
    .waddr_i   (tbl_csr_i),
    .wexists_i (tbl_exists_i),
    .wver_i    (tbl_minver_i),
    .laddr_i   (req_csr_i),
    .hit_o     (hit),
    .ver_o     (need_ver)
  );

  csr_priv_gate #(.AW(CSR_AW)) u_gate (
    .addr_i      (req_csr_i),
    .wr_i        (req_wr_i),
    .priv_i      (priv_i),
    .virt_i      (virt_i),
    .ro_fault_o  (ro_fault),
    .deny_ill_o  (deny_ill),
    .deny_virt_o (deny_virt)
  );

  // Priority: enable, existence (incl. version), then access control.
  always_comb begin
    if (!csr_en_i)                res_d = RES_ILLEGAL;
    else if (!hit)                res_d = RES_ILLEGAL;
    else if (need_ver > cfg_ver_i) res_d = RES_ILLEGAL;
    else if (ro_fault)            res_d = RES_ILLEGAL;
    else if (deny_ill)            res_d = RES_ILLEGAL;
    else if (deny_virt)           res_d = RES_VIRTUAL;
    else                          res_d = RES_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= RES_NONE;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
endmodule

// File: rtl/csr_access_checker_sva.sv
module csr_access_checker_sva #(
  parameter int unsigned CSR_AW = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [CSR_AW-1:0] req_csr_i,
  input logic              req_wr_i,
  input logic [1:0]        priv_i,
  input logic              virt_i,
  input logic              csr_en_i,
  input logic              valid_o,
  input logic [1:0]        result_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!valid_o && result_o == 2'b00);
    end
  end

  p_strobe_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !valid_o);
  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(result_o));
  p_disabled_ill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !csr_en_i) |=> result_o == 2'b01);
  p_ro_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_wr_i && req_csr_i[11:10] == 2'b11) |=> result_o == 2'b01);
  p_virt_needs_guest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !(virt_i && priv_i != 2'b11)) |=> result_o != 2'b10);
  p_mcsr_guest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && virt_i && req_csr_i[9:8] == 2'b11) |=> result_o != 2'b10);
  p_code_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> result_o != 2'b11);
endmodule

bind csr_access_checker csr_access_checker_sva #(.CSR_AW(CSR_AW)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_csr_i   (req_csr_i),
  .req_wr_i    (req_wr_i),
  .priv_i      (priv_i),
  .virt_i      (virt_i),
  .csr_en_i    (csr_en_i),
  .valid_o     (valid_o),
  .result_o    (result_o)
);

// File: tb/test_csr_access_checker.sv
module test_csr_access_checker;
  localparam int CLK_PERIOD = 10;
  localparam int N_SLOTS = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tbl_we_i = 1'b0;
  logic [2:0]  tbl_slot_i = '0;
  logic [11:0] tbl_csr_i = '0;
  logic        tbl_exists_i = 1'b0;
  logic [1:0]  tbl_minver_i = '0;
  logic        req_valid_i = 1'b0;
  logic [11:0] req_csr_i = '0;
  logic        req_wr_i = 1'b0;
  logic [1:0]  priv_i = 2'b11;
  logic        virt_i = 1'b0;
  logic        csr_en_i = 1'b1;
  logic [1:0]  cfg_ver_i = 2'd2;
  logic        valid_o;
  logic [1:0]  result_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  csr_access_checker i_csr_access_checker (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // Behavioural model of the table and the verdict
  int m_addr [N_SLOTS];
  bit m_ex   [N_SLOTS];
  int m_ver  [N_SLOTS];
  bit exp_valid = 0;
  int exp_res = 0;

  function automatic int model(int a, bit w, int p, bit v, bit en, int cfg);
    int found = -1;
    int lvl, rank;
    if (!en) return 1;
    foreach (m_addr[k]) if (m_ex[k] && m_addr[k] == a) found = k;
    if (found < 0) return 1;
    if (m_ver[found] > cfg) return 1;
    if (w && ((a >> 10) & 3) == 3) return 1;
    lvl = (a >> 8) & 3;
    if (v && p != 3) begin
      if (lvl == 3) return 1;
      rank = (p == 1) ? 1 : 0;   // VS reaches S-level, VU reaches U-level
      return (lvl > rank) ? 2 : 0;
    end
    rank = (p == 3) ? 3 : (p == 1) ? 2 : 0;
    return (lvl > rank) ? 1 : 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_valid <= 0;
      exp_res   <= 0;
      foreach (m_ex[k]) begin m_ex[k] = 0; m_addr[k] = 0; m_ver[k] = 0; end
    end else begin
      exp_valid <= req_valid_i;
      if (req_valid_i)
        exp_res <= model(int'(req_csr_i), req_wr_i, int'(priv_i), virt_i, csr_en_i, int'(cfg_ver_i));
      if (tbl_we_i) begin
        m_addr[tbl_slot_i] = int'(tbl_csr_i);
        m_ex[tbl_slot_i]   = tbl_exists_i;
        m_ver[tbl_slot_i]  = int'(tbl_minver_i);
      end
    end
  end

  // Per-clock comparison against the model (R2, R10)
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      n_run++;
      if (valid_o !== exp_valid || int'(result_o) != exp_res || result_o == 2'b11) begin
        n_fail++;
        $display("FAIL R2/R10 model: valid=%0b res=%0d expected valid=%0b res=%0d",
                 valid_o, result_o, exp_valid, exp_res);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load(int slot, int a, bit ex, int ver);
    @(negedge clk_i);
    tbl_we_i = 1; tbl_slot_i = 3'(slot); tbl_csr_i = 12'(a);
    tbl_exists_i = ex; tbl_minver_i = 2'(ver);
    @(negedge clk_i);
    tbl_we_i = 0;
  endtask

  task automatic run(string tag, int a, bit w, int p, bit v, int exp);
    @(negedge clk_i);
    req_valid_i = 1; req_csr_i = 12'(a); req_wr_i = w; priv_i = 2'(p); virt_i = v;
    @(negedge clk_i);
    req_valid_i = 0;
    check(tag, int'(valid_o), 1);
    check(tag, int'(result_o), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid", int'(valid_o), 0);
    check("R1 result", int'(result_o), 0);
    rst_ni = 1;

    load(0, 'h300, 1, 0);
    load(1, 'h100, 1, 0);
    load(2, 'h600, 1, 1);
    load(3, 'h200, 1, 1);
    load(4, 'hC00, 1, 0);
    load(5, 'h14D, 1, 3);
    load(6, 'hE12, 1, 1);
    load(7, 'h001, 1, 0);

    run("R10 pass", 'h300, 1, 3, 0, 0);
    csr_en_i = 0;
    run("R3 mcsr", 'h300, 0, 3, 0, 1);
    run("R3 user", 'h001, 0, 0, 0, 1);
    run("R3 absent guest", 'h777, 0, 1, 1, 1);
    csr_en_i = 1;
    run("R4 absent", 'h123, 0, 3, 0, 1);
    run("R4 absent guest", 'h777, 1, 1, 1, 1);
    run("R5 newer", 'h14D, 0, 3, 0, 1);
    cfg_ver_i = 3;
    run("R5 ver ok", 'h14D, 0, 3, 0, 0);
    cfg_ver_i = 0;
    run("R5 no virt", 'h600, 0, 1, 1, 1);
    cfg_ver_i = 2;
    run("R6 ro write", 'hC00, 1, 3, 0, 1);
    run("R6 ro read", 'hC00, 0, 0, 0, 0);
    run("R6 before virt", 'hE12, 1, 1, 1, 1);
    run("R6 ro read guest", 'hE12, 0, 1, 1, 2);
    run("R7 U on S", 'h100, 0, 0, 0, 1);
    run("R7 S on S", 'h100, 1, 1, 0, 0);
    run("R7 HS on H", 'h600, 1, 1, 0, 0);
    run("R7 S on M", 'h300, 0, 1, 0, 1);
    run("R7 M on H", 'h600, 0, 3, 0, 0);
    run("R8 VS on H", 'h600, 0, 1, 1, 2);
    run("R8 VS on VS-csr", 'h200, 1, 1, 1, 2);
    run("R8 VS on S", 'h100, 0, 1, 1, 0);
    run("R8 VU on S", 'h100, 0, 0, 1, 2);
    run("R8 VU on U", 'h001, 1, 0, 1, 0);
    run("R9 VS on M", 'h300, 0, 1, 1, 1);
    run("R9 VU on M", 'h300, 0, 0, 1, 1);
    run("R8 M ignores virt", 'h600, 0, 3, 1, 0);

    // R2: idle cycles keep the last verdict, strobe low
    repeat (2) @(negedge clk_i);
    check("R2 idle valid", int'(valid_o), 0);
    check("R2 idle hold", int'(result_o), 0);
    // R2: back-to-back requests
    @(negedge clk_i);
    req_valid_i = 1; req_csr_i = 12'h300; priv_i = 2'b01; virt_i = 0; req_wr_i = 0;
    @(negedge clk_i);
    check("R2 b2b first", int'(result_o), 1);
    req_csr_i = 12'h600; virt_i = 1;
    @(negedge clk_i);
    req_valid_i = 0;
    check("R2 b2b second valid", int'(valid_o), 1);
    check("R2 b2b second", int'(result_o), 2);

    // R11: slot rewrite
    load(7, 'h001, 0, 0);
    run("R11 removed", 'h001, 0, 3, 0, 1);
    load(7, 'h002, 1, 0);
    run("R11 added", 'h002, 0, 3, 0, 0);

    repeat (2) @(negedge clk_i);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule